// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an internal request port and an external asynchronous 32K x 8 static RAM. Each accepted request is one single-byte read or write. The block turns it into a sequence of address, active-low chip select, output enable and write enable levels on the memory pins. The bidirectional data bus is split into three signals: a data-out bus, a data-in bus and a driver enable, which the pad ring joins into one bus.

The memory's datasheet limits are given as nanosecond parameters, together with the controller's clock period. At elaboration each phase length is rounded up to whole clocks, with a floor of one clock. A read holds select and output enable low for long enough to cover the cycle time, the address access time and the output-enable access time. It then samples the byte and returns it with a one-cycle valid pulse. After a read, the controller waits out the memory's output turn-off time before it accepts new work.

A write normally raises output enable and drives data for the whole strobe. A per-request flag can keep output enable low during the write. In that case the strobe is lengthened to cover the memory's write-to-high-impedance time plus the data setup time, and the data driver waits until the memory has let go of the bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, chip select, output enable and write enable are high, the data driver is off, `req_ready` is high and `rd_valid` is low.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, and while it is idle all three strobes are high and the driver is off.
- R3: A read (`req_write`=0) drives chip select low and output enable low, keeps write enable high, and holds the address for exactly N_RD clocks. N_RD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_AOE/CLK). The byte is sampled at the end of the last of these clocks.
- R4: The sampled byte appears on `rd_data` while `rd_valid` is high for exactly one clock. This happens in the clock after the last read-strobe clock, which is N_RD+1 clocks after the accepting edge.
- R5: A write with `req_keep_oe`=0 holds chip select and write enable low and output enable high for exactly N_WR clocks. N_WR is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK) and ceil(T_DW/CLK). Write enable low always comes with chip select low.
- R6: A write with `req_keep_oe`=1 holds output enable low for the whole strobe. The strobe lasts N_WRK = max(N_WR, ceil(T_WHZ/CLK)+ceil(T_DW/CLK)) clocks, and the driver stays off for the first ceil(T_WHZ/CLK) of them.
- R7: The driver is on only while write enable is low. It turns off on the same edge at which write enable rises. The address and the driven byte are stable across the strobe, and the byte written is the request's data.
- R8: After a read, `req_ready` stays low for ceil(T_OHZ/CLK) clocks after the strobes rise. This prevents any driving while the memory may still hold the bus.
- R9: Each phase count is its nanosecond interval divided by the clock period and rounded up, and it is never less than one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_keep_oe | input | 1 | Keep output enable low during this write |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | DATA_W | Byte returned by a read |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dout | output | DATA_W | Byte toward the memory |
| sram_din | input | DATA_W | Byte from the memory |
| sram_dq_oe | output | 1 | Data driver enable, active high |

## Verification
The assertions check the following on every cycle: the pin combinations (write enable only under chip select, read pins during a read), a quiet bus while idle, the driver confined to the write strobe, the driver held off early in a held-output-enable write, a stable address under select, and the single-cycle read pulse. Exact phase lengths, latency, turnaround length and data integrity can only be shown by the bench scenarios. The bench's memory model returns garbage until enough clocks have passed since the address and output enable settled, and it flags any driving while the model may still hold the bus. The bench sweeps every address of a small configuration, mixes both write modes, and places writes directly after reads.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and elaboration-time timing arithmetic
// for the static RAM controller.
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } ctl_state_t;

    // Round an interval in ns up to whole clocks, never below one (R9).
    function automatic int clocks_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
// Module: sram_ctl_fsm
// Sequences the memory strobes and the data driver enable. Phase lengths
// arrive as clock counts (each at least one). It assumes the datapath
// latches address and data on `load` and samples read data on `cap`.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int N_RD  = 4,
    parameter int N_WR  = 3,
    parameter int N_WRK = 5,
    parameter int N_WHZ = 2,
    parameter int N_OHZ = 2,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_keep_oe,
    output logic ready,
    output logic load,
    output logic cap,
    output logic cs_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);

    ctl_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic             keep_q;
    logic [CNT_W-1:0] wr_last;

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(N_OHZ - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(N_WR - 1);
    localparam logic [CNT_W-1:0] WRK_LAST  = CNT_W'(N_WRK - 1);
    localparam logic [CNT_W-1:0] DRV_ON    = CNT_W'(N_WHZ - 1);
    localparam logic [CNT_W-1:0] WHZ_CNT   = CNT_W'(N_WHZ);

    // Handshake and phase-end decode.
    always_comb begin
        ready   = (st == ST_IDLE);
        load    = ready && req_valid;
        cap     = (st == ST_READ) && (cnt == RD_LAST);
        wr_last = keep_q ? WRK_LAST : WR_LAST;
    end

    // State, phase counter and registered strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            keep_q <= 1'b0;
            cs_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            dq_oe  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cnt    <= '0;
                        cs_n   <= 1'b0;
                        keep_q <= req_keep_oe;
                        if (req_write) begin
                            st    <= ST_WRITE;
                            we_n  <= 1'b0;
                            oe_n  <= !req_keep_oe;
                            dq_oe <= !req_keep_oe;
                        end else begin
                            st   <= ST_READ;
                            oe_n <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt == RD_LAST) begin
                        cs_n <= 1'b1;
                        oe_n <= 1'b1;
                        cnt  <= '0;
                        st   <= ST_TURN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt == TURN_LAST) st <= ST_IDLE;
                    else                  cnt <= cnt + 1'b1;
                end
                ST_WRITE: begin
                    if (cnt == wr_last) begin
                        cs_n  <= 1'b1;
                        oe_n  <= 1'b1;
                        we_n  <= 1'b1;
                        dq_oe <= 1'b0;
                        st    <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (keep_q && cnt == DRV_ON) dq_oe <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_drv_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !cs_n));
    assert_we_under_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cs_n && oe_n && we_n && !dq_oe));
    assert_read_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> (!cs_n && !oe_n && we_n));
    assert_drv_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE && keep_q && cnt < WHZ_CNT) |-> !dq_oe);

endmodule

// File: rtl/sram_ctl_dpath.sv
// Module: sram_ctl_dpath
// Holds the address and write byte for the active request and returns the
// sampled read byte with a one-clock valid pulse. It assumes `load` occurs
// only while idle and `cap` only on the last read-strobe clock.
module sram_ctl_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cap,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] sram_din,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Latch the request fields for the length of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dout <= '0;
        end else if (load) begin
            sram_addr <= req_addr;
            sram_dout <= req_wdata;
        end
    end

    // Sample the memory byte and raise the one-clock return pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (cap) rd_data <= sram_din;
        end
    end

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(sram_addr));

endmodule

// File: rtl/sram_ctl.sv
// Module: sram_ctl
// Top of the static RAM controller. It converts the ns timing parameters
// into clock counts and connects the sequencer to the datapath. It assumes
// the pad ring joins sram_dout, sram_din and sram_dq_oe into one bus.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 2,
    parameter int T_RC_NS   = 8,
    parameter int T_AA_NS   = 8,
    parameter int T_AOE_NS  = 4,
    parameter int T_OHZ_NS  = 4,
    parameter int T_WP_NS   = 6,
    parameter int T_AW_NS   = 6,
    parameter int T_DW_NS   = 5,
    parameter int T_WHZ_NS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_keep_oe,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dout,
    input  logic [DATA_W-1:0] sram_din,
    output logic              sram_dq_oe
);

    localparam int N_RD  = imax(clocks_for(T_RC_NS, CLK_NS),
                           imax(clocks_for(T_AA_NS, CLK_NS), clocks_for(T_AOE_NS, CLK_NS)));
    localparam int N_DW  = clocks_for(T_DW_NS, CLK_NS);
    localparam int N_WHZ = clocks_for(T_WHZ_NS, CLK_NS);
    localparam int N_OHZ = clocks_for(T_OHZ_NS, CLK_NS);
    localparam int N_WR  = imax(N_DW, imax(clocks_for(T_WP_NS, CLK_NS), clocks_for(T_AW_NS, CLK_NS)));
    localparam int N_WRK = imax(N_WR, N_WHZ + N_DW);
    localparam int CNT_W = $clog2(imax(imax(N_RD, N_WRK), N_OHZ) + 1);

    logic load, cap;

    sram_ctl_fsm #(
        .N_RD(N_RD), .N_WR(N_WR), .N_WRK(N_WRK),
        .N_WHZ(N_WHZ), .N_OHZ(N_OHZ), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_keep_oe(req_keep_oe),
        .ready(req_ready), .load(load), .cap(cap),
        .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n), .dq_oe(sram_dq_oe)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .load(load), .cap(cap), .cs_n(sram_cs_n),
        .req_addr(req_addr), .req_wdata(req_wdata), .sram_din(sram_din),
        .sram_addr(sram_addr), .sram_dout(sram_dout),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: tb/sram_ctl_test.sv
// Bench: a behavioural memory model with cycle-counted access and bus-hold
// windows, a full address sweep of an 8-bit-address build, and mixed modes.
// The timing parameter describes a 2 ns target clock; the bench clock runs
// at 50 MHz because only clock counts matter.
module sram_ctl_test;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CK = 2;
    // Expected phase lengths, rounded up from the ns limits (R9).
    localparam int B_RD  = 4;  // max(8/2, 8/2, 4/2)
    localparam int B_WR  = 3;  // max(6/2, 6/2, ceil(5/2))
    localparam int B_WHZ = 2;
    localparam int B_OHZ = 2;
    localparam int B_WRK = 5;  // max(3, 2 + 3)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_keep_oe = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, cs_n, oe_n, we_n, dq_oe;
    logic [DW-1:0] rd_data, dout;
    logic [DW-1:0] din = 8'hEE;
    logic [AW-1:0] addr;

    int tests = 0, fails = 0, mtests = 0, mfails = 0;
    int cycles = 0;
    logic exp_keep = 1'b0;
    logic [DW-1:0] mem [256];

    always #10 clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CK)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_keep_oe(req_keep_oe), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(addr), .sram_cs_n(cs_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
        .sram_dout(dout), .sram_din(din), .sram_dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 29 + 7 + pass * 83) ^ (a >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model and pin monitor, sampled mid-cycle.
    int wlen = 0, dlen = 0, rage = 0, tail = 0;
    logic [AW-1:0] wadr = '0, radr = '0;
    logic [DW-1:0] wdat = '0;
    logic sawoe = 1'b0;
    always @(negedge clk) begin
        logic memdrv, ract;
        if (!rst_n) begin
            wlen = 0; dlen = 0; rage = 0; tail = 0;
        end else begin
            ract = !cs_n && !oe_n && we_n;
            memdrv = ract || (tail > 0);
            if (!we_n) begin
                if (wlen == 0) begin wadr = addr; sawoe = !oe_n; end
                else if (addr != wadr) begin
                    mtests++; mfails++;
                    $display("FAIL R7 address moved actual=%0d expected=%0d", addr, wadr);
                end
                if (!oe_n && wlen < B_WHZ) memdrv = 1'b1;
                if (dq_oe) begin dlen++; wdat = dout; end
                wlen++;
            end
            if (dq_oe && (memdrv || we_n)) begin
                mtests++; mfails++;
                $display("FAIL R8 bus contention actual=%0d expected=%0d", 1, 0);
            end
            if (we_n && wlen > 0) begin
                mtests += 3;
                if (sawoe != exp_keep) begin
                    mfails++;
                    $display("FAIL R6 oe during write actual=%0d expected=%0d", sawoe, exp_keep);
                end
                if (wlen != (sawoe ? B_WRK : B_WR)) begin
                    mfails++;
                    $display("FAIL R5 strobe length actual=%0d expected=%0d",
                             wlen, sawoe ? B_WRK : B_WR);
                end
                if (dlen != (sawoe ? B_WRK - B_WHZ : B_WR)) begin
                    mfails++;
                    $display("FAIL R6 driven clocks actual=%0d expected=%0d",
                             dlen, sawoe ? B_WRK - B_WHZ : B_WR);
                end
                mem[wadr] = wdat;
                wlen = 0; dlen = 0;
            end
            if (ract) begin
                rage = (rage > 0 && addr == radr) ? rage + 1 : 1;
                radr = addr;
                tail = B_OHZ;
            end else begin
                rage = 0;
                if (tail > 0) tail--;
            end
            din = (ract && rage >= B_RD) ? mem[addr] : 8'hEE;
        end
    end

    task automatic issue(input bit wr, input int a, input logic [DW-1:0] d, input bit keep);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
        req_wdata = d; req_keep_oe = keep;
        if (wr) exp_keep = keep;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit keep);
        issue(1'b1, a, d, keep);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        int n;
        issue(1'b0, a, 8'h00, 1'b0);
        n = 1;
        while (!rd_valid && n < 40) begin @(negedge clk); n++; end
        chk(rd_data == exp, "R3 read data", rd_data, exp);
        chk(n == B_RD + 1, "R4 read latency", n, B_RD + 1);
        n = 0;
        while (!req_ready && n < 40) begin
            @(negedge clk); n++;
            if (n == 1) chk(!rd_valid, "R4 single pulse", rd_valid, 0);
        end
        chk(n == B_OHZ, "R8 turnaround", n, B_OHZ);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests + mtests + 1, fails + mfails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(cs_n && oe_n && we_n && !dq_oe, "R1 pins in reset", {cs_n, oe_n, we_n, dq_oe}, 14);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && oe_n && we_n && !dq_oe, "R1 pins after reset", {cs_n, oe_n, we_n, dq_oe}, 14);
        chk(req_ready && !rd_valid, "R1 ready idle", {req_ready, rd_valid}, 2);
        // Full sweep, both write modes (R5, R6, R7).
        for (int a = 0; a < 256; a++) do_write(a, pat(a, 0), a[0] ^ a[4]);
        // Reads in reverse order (R3, R4, R8, R9).
        for (int a = 255; a >= 0; a--) do_read(a, pat(a, 0));
        // Write directly after read on each address, then read back (R8, R7).
        for (int a = 0; a < 64; a++) begin
            do_read(a, pat(a, 0));
            do_write(a, pat(a, 1), a[1]);
            do_read(a, pat(a, 1));
        end
        // Extreme data values (R7).
        do_write(8'hFF, 8'h00, 1'b1);
        do_read(8'hFF, 8'h00);
        do_write(8'h00, 8'hFF, 1'b0);
        do_read(8'h00, 8'hFF);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
        $finish;
    end

endmodule